// File: doc/BRIEF.md
# Complementary PWM Timer with Deadband

This block is a 16-bit up-counting timer that produces a pulse-width modulated signal on a main output and, in dual mode, its complement on a second output. A prescaler divides the system clock by a power of two, and the counter advances once per prescaler tick. Each period runs the count from 1 up to a reload value. The output phase flips when the count passes a compare value and again at reload. A polarity bit selects which of the two phases drives the main output high.

A programmable deadband keeps the two outputs from overlapping. When the phase changes, the output that was on drops at once. The output that is turning on stays low for the deadband length, in system clock cycles. The first period after enabling starts from a loaded start count, so it can be shorter than the steady period. Every reload raises a single-cycle interrupt pulse. Software sets up the block through a narrow write port of address and data, one register per address.

Top module: `cpwm_timer`

## Requirements
- R1: After reset the block is disabled, and `pwmOut`, `pwmOutN` and `irqPulse` are all low.
- R2: The control register (address 3) holds the prescale exponent n in bits 3:1. The counter advances once every 2^n system clock cycles.
- R3: In steady state the count runs from 1 up to the reload value (address 2) and then returns to 1. Reload events are spaced reload × 2^n cycles apart.
- R4: Setting the enable bit (control bit 0) while the block is disabled loads the start count (address 0). The first reload then comes (reload − start + 1) × 2^n cycles later.
- R5: The polarity bit is control bit 4. With polarity 0, the main phase is active while count > compare (address 1). With polarity 1, it is active while count ≤ compare.
- R6: When the phase changes, the output that was on goes low in the same cycle. The output that is turning on stays low for D cycles, where D is the deadband register (address 4).
- R7: The dual flag is control bit 5. When it is set, `pwmOutN` is active in the opposite phase under the same deadband rule. When it is clear, `pwmOutN` stays low.
- R8: Clearing the enable bit freezes the count, forces both outputs low and stops interrupts.
- R9: `irqPulse` is high for exactly the cycle after each tick on which the count equals the reload value.
- R10: `pwmOut` and `pwmOutN` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address: 0 start, 1 compare, 2 reload, 3 control, 4 deadband |
| wrData | input | 16 | Register write data |
| pwmOut | output | 1 | Main PWM output |
| pwmOutN | output | 1 | Complementary PWM output |
| irqPulse | output | 1 | One-cycle pulse after each reload |

## Verification
The hardest case to reach is a phase change that lands while an earlier deadband window is still counting. A second hard case is a first pass that starts from a start count other than 1 while a large prescale is active. Both depend on how the count, the prescaler and the deadband line up in time.

The stimulus reaches them by reprogramming polarity, start count and deadband while the block is disabled, and then re-enabling it. This puts the first phase change in the same cycle as the counter load. In one case the compare value sits one below the reload value, so each active phase lasts a single count. A behavioural model runs alongside and checks both outputs and the interrupt in every cycle. Directed interval measurements confirm the first-pass and steady-state periods.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // enable rising: load start count
    logic tick;   // prescaler tick: advance count
  } cpwmStb_t;

  localparam int ADDR_START = 0;
  localparam int ADDR_CMP   = 1;
  localparam int ADDR_REL   = 2;
  localparam int ADDR_CTRL  = 3;
  localparam int ADDR_DEAD  = 4;
endpackage

// File: rtl/cpwm_ctrl.sv
`timescale 1ns/1ps
module cpwm_ctrl
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3,
  parameter int DB_W   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output cpwmStb_t          stb,
  output logic [CNT_W-1:0]  startVal,
  output logic [CNT_W-1:0]  cmpVal,
  output logic [CNT_W-1:0]  relVal,
  output logic [DB_W-1:0]   dbVal,
  output logic              polSel,
  output logic              dualEn,
  output logic              runEn
);
  localparam int PSC_CNT_W = (1 << PSC_W) - 1;
  localparam int EN_BIT    = 0;
  localparam int PSC_LSB   = 1;
  localparam int POL_BIT   = PSC_LSB + PSC_W;
  localparam int DUAL_BIT  = POL_BIT + 1;

  logic [PSC_W-1:0]     pscSel;
  logic [PSC_CNT_W-1:0] pscCnt;
  logic [PSC_CNT_W:0]   maskWide;
  logic [PSC_CNT_W-1:0] pscMask;
  logic                 ctrlWr;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
  assign maskWide = ({{PSC_CNT_W{1'b0}}, 1'b1} << pscSel) - {{PSC_CNT_W{1'b0}}, 1'b1};
  assign pscMask  = maskWide[PSC_CNT_W-1:0];

  assign stb.load = ctrlWr && wrData[EN_BIT] && !runEn;
  assign stb.tick = runEn && ((pscCnt & pscMask) == pscMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startVal <= '0;
      cmpVal   <= '0;
      relVal   <= '0;
      dbVal    <= '0;
      pscSel   <= '0;
      polSel   <= 1'b0;
      dualEn   <= 1'b0;
      runEn    <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(ADDR_START): startVal <= wrData;
        ADDR_W'(ADDR_CMP):   cmpVal   <= wrData;
        ADDR_W'(ADDR_REL):   relVal   <= wrData;
        ADDR_W'(ADDR_DEAD):  dbVal    <= wrData[DB_W-1:0];
        ADDR_W'(ADDR_CTRL): begin
          runEn  <= wrData[EN_BIT];
          pscSel <= wrData[PSC_LSB +: PSC_W];
          polSel <= wrData[POL_BIT];
          dualEn <= wrData[DUAL_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pscCnt <= '0;
    else if (stb.load) pscCnt <= '0;
    else if (runEn)    pscCnt <= pscCnt + 1'b1;
  end

  // R4
  load_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (runEn && $stable(startVal)));
endmodule

// File: rtl/cpwm_datapath.sv
`timescale 1ns/1ps
module cpwm_datapath
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cpwmStb_t         stb,
  input  logic [CNT_W-1:0] startVal,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic [CNT_W-1:0] relVal,
  input  logic [DB_W-1:0]  dbVal,
  input  logic             polSel,
  input  logic             dualEn,
  input  logic             runEn,
  output logic             pwmOut,
  output logic             pwmOutN,
  output logic             irqPulse
);
  logic [CNT_W-1:0] cntQ;
  logic [DB_W-1:0]  dbCnt;
  logic [DB_W-1:0]  dbRemain;
  logic             prevPhase;
  logic             phase;
  logic             atReload;
  logic             settled;
  logic             irqQ;

  assign atReload = (cntQ == relVal);
  assign phase    = polSel ? (cntQ <= cmpVal) : (cntQ > cmpVal);
  assign dbRemain = (phase != prevPhase) ? dbVal : dbCnt;
  assign settled  = (dbRemain == '0);

  assign pwmOut   = runEn && phase && settled;
  assign pwmOutN  = runEn && dualEn && !phase && settled;
  assign irqPulse = irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      irqQ <= 1'b0;
    end else begin
      irqQ <= stb.tick && atReload;
      if (stb.load)
        cntQ <= startVal;
      else if (stb.tick)
        cntQ <= atReload ? CNT_W'(1) : cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPhase <= 1'b0;
      dbCnt     <= '0;
    end else begin
      prevPhase <= phase;
      dbCnt     <= settled ? '0 : dbRemain - 1'b1;
    end
  end

  // R9
  irq_count_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (cntQ == CNT_W'(1)));
  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.tick || stb.load) |=> $stable(cntQ));
  // R6
  db_gap_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pwmOut) && dbVal != '0) |-> !$past(pwmOutN));
  // R6
  db_gap_comp_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pwmOutN) && dbVal != '0) |-> !$past(pwmOut));
endmodule

// File: rtl/cpwm_timer.sv
`timescale 1ns/1ps
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3,
  parameter int DB_W   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmOut,
  output logic              pwmOutN,
  output logic              irqPulse
);
  cpwmStb_t         stb;
  logic [CNT_W-1:0] startVal, cmpVal, relVal;
  logic [DB_W-1:0]  dbVal;
  logic             polSel, dualEn, runEn;

  cpwm_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DB_W(DB_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stb(stb), .startVal(startVal), .cmpVal(cmpVal), .relVal(relVal),
    .dbVal(dbVal), .polSel(polSel), .dualEn(dualEn), .runEn(runEn)
  );

  cpwm_datapath #(.CNT_W(CNT_W), .DB_W(DB_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startVal(startVal), .cmpVal(cmpVal),
    .relVal(relVal), .dbVal(dbVal), .polSel(polSel), .dualEn(dualEn),
    .runEn(runEn), .pwmOut(pwmOut), .pwmOutN(pwmOutN), .irqPulse(irqPulse)
  );

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pwmOut && pwmOutN));
endmodule

// File: tb/cpwm_timer_bench.sv
`timescale 1ns/1ps
module cpwm_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pwmOut, pwmOutN, irqPulse;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmpOn = 0;
  string curReq = "R5";

  always #2.5 clk = ~clk;

  cpwm_timer u_cpwm_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .pwmOutN(pwmOutN), .irqPulse(irqPulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Behavioural reference model
  int mEn, mPsc, mPol, mDual, mStart, mCmp, mRel, mDb;
  int mCnt, mCyc, mPrev, mSince, mIrq;

  function automatic int modelPhase();
    return mPol ? int'(mCnt <= mCmp) : int'(mCnt > mCmp);
  endfunction

  function automatic int modelSince(input int ph);
    if (ph != mPrev) return 0;
    return (mSince < 1000) ? mSince + 1 : mSince;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mPsc = 0; mPol = 0; mDual = 0; mStart = 0; mCmp = 0; mRel = 0; mDb = 0;
      mCnt = 0; mCyc = 0; mPrev = 0; mSince = 1000; mIrq = 0;
    end else begin
      int ph, s, div;
      bit tick;
      ph = modelPhase();
      s = modelSince(ph);
      mSince = s;
      mPrev = ph;
      div = 1 << mPsc;
      tick = (mEn != 0) && ((mCyc % div) == div - 1);
      mIrq = (tick && mCnt == mRel) ? 1 : 0;
      if (tick) mCnt = (mCnt == mRel) ? 1 : (mCnt + 1) % 65536;
      if (mEn != 0) mCyc++;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mStart = wrData;
          3'd1: mCmp = wrData;
          3'd2: mRel = wrData;
          3'd4: mDb = wrData[7:0];
          3'd3: begin
            if (wrData[0] && mEn == 0) begin mCnt = mStart; mCyc = 0; end
            mEn = wrData[0]; mPsc = wrData[3:1]; mPol = wrData[4]; mDual = wrData[5];
          end
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      int ph, s;
      bit eMain, eComp;
      ph = modelPhase();
      s = modelSince(ph);
      eMain = (mEn != 0) && (ph != 0) && (s >= mDb);
      eComp = (mEn != 0) && (mDual != 0) && (ph == 0) && (s >= mDb);
      chk(pwmOut == eMain, curReq, "pwmOut", pwmOut, eMain);
      chk(pwmOutN == eComp, "R7", "pwmOutN", pwmOutN, eComp);
      chk(irqPulse == (mIrq != 0), "R9", "irqPulse", irqPulse, mIrq);
      chk(!(pwmOut && pwmOutN), "R10", "overlap", int'(pwmOut && pwmOutN), 0);
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int ctrlWord(input int en, input int psc, input int pol, input int dual);
    return en | (psc << 1) | (pol << 4) | (dual << 5);
  endfunction

  task automatic waitIrq(output int k);
    k = 0;
    while (!irqPulse && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "WDOG", "watchdog expired", 1, 0);
    report();
  end

  initial begin
    int k, k2;
    int maxN;
    runCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pwmOut == 0, "R1", "pwmOut after reset", pwmOut, 0);
    chk(pwmOutN == 0, "R1", "pwmOutN after reset", pwmOutN, 0);
    chk(irqPulse == 0, "R1", "irqPulse after reset", irqPulse, 0);
    cmpOn = 1;

    // Basic run, polarity 0, no deadband
    curReq = "R5";
    wr(0, 1); wr(1, 3); wr(2, 8); wr(4, 0);
    wr(3, ctrlWord(1, 0, 0, 1));
    waitIrq(k);
    chk(k == 8, "R4", "first pass from start 1", k, 8);
    @(negedge clk); waitIrq(k2);
    chk(k2 + 1 == 8, "R3", "steady period", k2 + 1, 8);
    runCycles(20);

    // Disable: frozen, outputs low
    wr(3, ctrlWord(0, 0, 0, 1));
    maxN = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmOut || pwmOutN || irqPulse) maxN++;
    end
    chk(maxN == 0, "R8", "activity while disabled", maxN, 0);

    // Polarity 1, deadband 2, start 5
    curReq = "R6";
    wr(4, 2); wr(0, 5); wr(1, 4); wr(2, 8);
    wr(3, ctrlWord(1, 0, 1, 1));
    waitIrq(k);
    chk(k == 4, "R4", "first pass from start 5", k, 4);
    runCycles(40);

    // Prescale 2^2, deadband 1
    curReq = "R2";
    wr(3, ctrlWord(0, 2, 0, 1));
    wr(4, 1); wr(0, 1); wr(1, 3);
    wr(3, ctrlWord(1, 2, 0, 1));
    waitIrq(k);
    chk(k == 32, "R2", "first pass with prescale 4", k, 32);
    @(negedge clk); waitIrq(k2);
    chk(k2 + 1 == 32, "R3", "steady period with prescale 4", k2 + 1, 32);
    runCycles(10);

    // Dual off, deadband 3, prescale 2^1
    curReq = "R7";
    wr(3, ctrlWord(0, 1, 0, 0));
    wr(4, 3); wr(1, 5); wr(2, 9);
    wr(3, ctrlWord(1, 1, 0, 0));
    maxN = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwmOutN) maxN++;
    end
    chk(maxN == 0, "R7", "pwmOutN with dual clear", maxN, 0);

    // Compare one below reload: single-count active phase
    curReq = "R5";
    wr(3, ctrlWord(0, 0, 0, 1));
    wr(4, 0); wr(0, 1); wr(1, 7); wr(2, 8);
    wr(3, ctrlWord(1, 0, 0, 1));
    maxN = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (pwmOut) maxN++;
    end
    chk(maxN == 4, "R5", "main high cycles over 4 periods", maxN, 4);

    cmpOn = 0;
    report();
  end
endmodule